// File: doc/BRIEF.md
# Sticky Interrupt Flag Register Bank

This block collects single-cycle event pulses from the internal logic of a serially controlled USB host peripheral. Each pulse sets a sticky flag bit. Software finds the flags through a plain address/data/strobe register port. Software can poll every flag whether or not it is enabled. An enable register chooses which flags may raise the one shared, active-high interrupt output. That output comes from a flip-flop, so it cannot glitch. A fixed revision value is also readable through the port.

Two flags break the usual write-one-to-clear rule. The first is the receive-data-available flag. Clearing it while it is set sends a one-cycle pulse to the receive buffer logic, handing the current buffer back. A clear of that flag when it is already clear does nothing: there is no pulse and no state change. The second is the send-buffer-available flag. Software cannot clear it, because it follows a level that the send-buffer logic drives.

Top module: `irqbank_top`

## Requirements
- R1: After a synchronous active-low reset with `tx_free` low, the flag register (address 4) and the enable register (address 5) read 0x00, and `irq_o` and `rx_release_o` are low.
- R2: Address 18 always reads 0x13, and a write to address 18 changes nothing.
- R3: A pulse on `ev_pulse[i]` (for any bit i other than bit 1) sets flag bit i at the next clock edge. The bit stays set until software clears it, and it is readable whatever the enable bits hold.
- R4: A write to address 4 clears every flag bit written as 1 and leaves every bit written as 0 unchanged.
- R5: If an event pulse and a clearing write hit the same bit in the same cycle, the bit is set after the edge.
- R6: Address 5 is a read/write enable register. After every clock edge, `irq_o` equals the OR over all bits of (flag AND enable), using the register values after that same edge.
- R7: A write to address 4 with bit 0 set, while flag bit 0 (receive data available) is set, drives `rx_release_o` high for exactly the one cycle that follows the edge. Flag bit 0 clears at that same edge unless the R5 collision rule keeps it set.
- R8: A write to address 4 with bit 0 set, while flag bit 0 is clear, leaves `rx_release_o` low and flag bit 0 clear.
- R9: Flag bit 1 (send buffer available) takes the value of `tx_free` at each clock edge. Clearing writes and `ev_pulse[1]` do not affect it.
- R10: Addresses other than 4, 5 and 18 read 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_pulse | input | 8 | Single-cycle event pulses, one per flag bit |
| tx_free | input | 1 | Level from the send-buffer logic: a buffer is free |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | 5 | Register address for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational from the registers |
| irq_o | output | 1 | Registered, active-high combined interrupt |
| rx_release_o | output | 1 | One-cycle pulse: the receive buffer is handed back |

## Verification
The assertions assume that `ev_pulse` bits are synchronous to `clk` and that `reg_wr` lasts one cycle per access. They also assume that `reg_addr` is stable while `reg_rdata` is read. The stimulus drives every input on the falling edge and returns `ev_pulse` and `reg_wr` to zero after each cycle. The random phase keeps events sparse and aims writes at the mapped addresses, the revision address and one unmapped address. Writes in that phase often land on bits that are already clear. As a result, clears of an idle receive flag and event/clear collisions occur many times.

// File: rtl/irq_pkg.sv
// Package: shared sizes, register addresses, flag positions and cell kinds
// for the sticky interrupt flag bank. Assumes an 8-bit data path.
package irq_pkg;
    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 5;
    localparam int FLAG_ADDR = 4;
    localparam int EN_ADDR   = 5;
    localparam int REV_ADDR  = 18;
    localparam logic [7:0] REV_VALUE = 8'h13;
    localparam int RX_BIT    = 0;
    localparam int TX_BIT    = 1;

    typedef enum logic [0:0] {
        CELL_STICKY = 1'b0,
        CELL_LEVEL  = 1'b1
    } cell_kind_e;
endpackage

// File: rtl/irq_flag_cell.sv
// One flag bit. A STICKY cell sets on set_i and clears on clr_i, and set wins
// over clear. A LEVEL cell copies lvl_i at every edge and ignores set and clear.
// It exposes both the next-state value and the registered value.
// Assumes the inputs are synchronous to clk.
module irq_flag_cell
    import irq_pkg::*;
#(
    parameter cell_kind_e KIND = CELL_STICKY
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic lvl_i,
    output logic flag_d_o,
    output logic flag_q_o
);
    logic flag_q;

    // Next-state value for the chosen cell kind.
    always_comb begin
        if (KIND == CELL_LEVEL) flag_d_o = lvl_i;
        else                    flag_d_o = set_i | (flag_q & ~clr_i);
    end

    // Flag storage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d_o;
    end

    assign flag_q_o = flag_q;
endmodule

// File: rtl/irq_reg_if.sv
// Register port decode. It turns a write strobe into a clear vector for the
// flag cells, holds the enable register, and muxes the read data.
// Assumes one write strobe per access. Reads are combinational from addr.
module irq_reg_if
    import irq_pkg::*;
#(
    parameter int DW        = DATA_W,
    parameter int AW        = ADDR_W,
    parameter int A_FLAG    = FLAG_ADDR,
    parameter int A_EN      = EN_ADDR,
    parameter int A_REV     = REV_ADDR,
    parameter logic [DW-1:0] REV_VAL = DW'(REV_VALUE)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [DW-1:0] flag_q_i,
    output logic [DW-1:0] clr_o,
    output logic [DW-1:0] en_d_o,
    output logic [DW-1:0] en_q_o,
    output logic [DW-1:0] rdata_o
);
    localparam logic [AW-1:0] FLAG_A = AW'(A_FLAG);
    localparam logic [AW-1:0] EN_A   = AW'(A_EN);
    localparam logic [AW-1:0] REV_A  = AW'(A_REV);

    logic          hit_flag;
    logic          hit_en;
    logic [DW-1:0] en_q;

    // Address decode for write strobes.
    always_comb begin
        hit_flag = wr_i && (addr_i == FLAG_A);
        hit_en   = wr_i && (addr_i == EN_A);
    end

    // Clear vector: bits written as 1 to the flag register.
    always_comb begin
        clr_o = hit_flag ? wdata_i : '0;
    end

    // Next-state value of the enable register.
    always_comb begin
        en_d_o = hit_en ? wdata_i : en_q;
    end

    // Enable register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d_o;
    end

    // Read data mux. Unmapped addresses return zero.
    always_comb begin
        unique case (addr_i)
            FLAG_A:  rdata_o = flag_q_i;
            EN_A:    rdata_o = en_q;
            REV_A:   rdata_o = REV_VAL;
            default: rdata_o = '0;
        endcase
    end

    assign en_q_o = en_q;
endmodule

// File: rtl/irq_out_stage.sv
// Output registers. The interrupt is computed from the next-state flags and
// enables, so it lines up with the registers. The receive-release request is
// registered into a one-cycle pulse. Both outputs come straight from flops.
module irq_out_stage #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] flag_d_i,
    input  logic [DW-1:0] en_d_i,
    input  logic          rel_req_i,
    output logic          irq_o,
    output logic          rel_o
);
    logic irq_d;

    // Combined interrupt request from the next-state values.
    always_comb begin
        irq_d = |(flag_d_i & en_d_i);
    end

    // Registered outputs, so neither can glitch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
            rel_o <= 1'b0;
        end else begin
            irq_o <= irq_d;
            rel_o <= rel_req_i;
        end
    end
endmodule

// File: rtl/irqbank_top.sv
// Sticky interrupt flag bank: the top level. Every bit is a sticky
// write-one-to-clear cell except the send-available bit, which is a level
// cell. A clear of the receive-available bit while it is set requests a
// buffer release. Assumes event pulses are one cycle long and synchronous.
module irqbank_top
    import irq_pkg::*;
#(
    parameter int DW      = DATA_W,
    parameter int AW      = ADDR_W,
    parameter int A_FLAG  = FLAG_ADDR,
    parameter int A_EN    = EN_ADDR,
    parameter int A_REV   = REV_ADDR,
    parameter int RXB     = RX_BIT,
    parameter int TXB     = TX_BIT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] ev_pulse,
    input  logic          tx_free,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq_o,
    output logic          rx_release_o
);
    logic [DW-1:0] clr_vec;
    logic [DW-1:0] flag_d;
    logic [DW-1:0] flag_q;
    logic [DW-1:0] en_d;
    logic [DW-1:0] en_q;
    logic          rel_req;

    irq_reg_if #(
        .DW(DW), .AW(AW), .A_FLAG(A_FLAG), .A_EN(A_EN), .A_REV(A_REV),
        .REV_VAL(DW'(REV_VALUE))
    ) u_regif (
        .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .addr_i(reg_addr),
        .wdata_i(reg_wdata), .flag_q_i(flag_q), .clr_o(clr_vec),
        .en_d_o(en_d), .en_q_o(en_q), .rdata_o(reg_rdata)
    );

    // One cell per flag bit; the parameter picks the kind.
    for (genvar i = 0; i < DW; i++) begin : g_cell
        localparam cell_kind_e K = (i == TXB) ? CELL_LEVEL : CELL_STICKY;
        irq_flag_cell #(.KIND(K)) u_cell (
            .clk(clk), .rst_n(rst_n), .set_i(ev_pulse[i]),
            .clr_i(clr_vec[i]), .lvl_i(tx_free),
            .flag_d_o(flag_d[i]), .flag_q_o(flag_q[i])
        );
    end

    // Release only when a clear hits a receive flag that is set now.
    always_comb begin
        rel_req = clr_vec[RXB] & flag_q[RXB];
    end

    irq_out_stage #(.DW(DW)) u_out (
        .clk(clk), .rst_n(rst_n), .flag_d_i(flag_d), .en_d_i(en_d),
        .rel_req_i(rel_req), .irq_o(irq_o), .rel_o(rx_release_o)
    );
endmodule

// File: rtl/irqbank_chk.sv
// Checker for irqbank_top, attached by bind. It observes the ports and the
// flag and enable registers. Assumes a single clock and a synchronous reset.
module irqbank_chk
    import irq_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic [DW-1:0] ev_pulse,
    input logic          tx_free,
    input logic          reg_wr,
    input logic [AW-1:0] reg_addr,
    input logic [DW-1:0] reg_rdata,
    input logic          irq_o,
    input logic          rx_release_o,
    input logic [DW-1:0] flag_q,
    input logic [DW-1:0] en_q
);
    localparam logic [DW-1:0] STICKY_M = ~(DW'(1) << TX_BIT);
    localparam logic [AW-1:0] FA = AW'(FLAG_ADDR);
    localparam logic [AW-1:0] RA = AW'(REV_ADDR);

    AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((flag_q & $past(ev_pulse & STICKY_M)) == $past(ev_pulse & STICKY_M))); // R3

    AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !(reg_wr && reg_addr == FA))
        |=> ((flag_q & $past(flag_q & STICKY_M)) == $past(flag_q & STICKY_M))); // R4

    AST_RELEASE_NEEDS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        rx_release_o |-> ($past(flag_q[RX_BIT]) && $past(reg_wr) && $past(reg_addr) == FA)); // R8

    AST_IRQ_MATCHES_REGS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == |(flag_q & en_q)); // R6

    AST_TX_FOLLOWS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (flag_q[TX_BIT] == $past(tx_free))); // R9

    AST_REV_CONSTANT: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == RA) |-> (reg_rdata == REV_VALUE)); // R2
endmodule

bind irqbank_top irqbank_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .tx_free(tx_free),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
    .irq_o(irq_o), .rx_release_o(rx_release_o), .flag_q(flag_q), .en_q(en_q)
);

// File: tb/irqbank_top_tb.sv
// Bench for irqbank_top: directed corner cases, then seeded random stimulus,
// compared against a model built from the requirements.
module irqbank_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] ev_pulse = '0;
    logic       tx_free = 1'b0;
    logic       reg_wr = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_o;
    logic       rx_release_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [7:0] m_flag = '0;
    logic [7:0] m_en = '0;
    logic       m_rel = 1'b0;

    always #4 clk = ~clk;

    irqbank_top u_dut (
        .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .tx_free(tx_free),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_o(irq_o), .rx_release_o(rx_release_o)
    );

    function automatic logic [7:0] exp_read(logic [4:0] a);
        case (a)
            5'd4:    return m_flag;
            5'd5:    return m_en;
            5'd18:   return 8'h13;
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // One clock cycle with the given inputs, followed by model update and output checks.
    task automatic cyc(logic [7:0] ev, logic txf, logic wr, logic [4:0] a, logic [7:0] wd);
        logic [7:0] clr;
        ev_pulse = ev; tx_free = txf; reg_wr = wr; reg_addr = a; reg_wdata = wd;
        @(posedge clk);
        clr = (wr && a == 5'd4) ? wd : 8'h00;
        m_rel = clr[0] & m_flag[0];
        m_flag = (m_flag & ~clr) | ev;
        m_flag[1] = txf;
        if (wr && a == 5'd5) m_en = wd;
        #2;
        chk("R6 irq", {7'd0, irq_o}, {7'd0, |(m_flag & m_en)});
        chk("R7 release", {7'd0, rx_release_o}, {7'd0, m_rel});
        @(negedge clk);
        ev_pulse = '0; reg_wr = 1'b0;
    endtask

    task automatic rd(string tag, logic [4:0] a);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp_read(a));
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0413));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        rd("R1 flag reset", 5'd4);
        rd("R1 enable reset", 5'd5);
        chk("R1 irq reset", {7'd0, irq_o}, 8'h00);
        chk("R1 release reset", {7'd0, rx_release_o}, 8'h00);
        @(negedge clk);

        // R2 revision readback, then a write to it is ignored
        rd("R2 revision", 5'd18);
        cyc(8'h00, 1'b0, 1'b1, 5'd18, 8'hFF);
        rd("R2 revision after write", 5'd18);
        rd("R2 flag unchanged", 5'd4);

        // R3 event sets a flag with its enable off
        cyc(8'h08, 1'b0, 1'b0, 5'd0, 8'h00);
        cyc(8'h00, 1'b0, 1'b0, 5'd0, 8'h00);
        rd("R3 sticky flag", 5'd4);
        chk("R3 no irq while masked", {7'd0, irq_o}, 8'h00);

        // R4 writing 0 keeps the bit; writing 1 clears it
        cyc(8'h00, 1'b0, 1'b1, 5'd4, 8'h00);
        rd("R4 zero write keeps", 5'd4);
        cyc(8'h00, 1'b0, 1'b1, 5'd4, 8'h08);
        rd("R4 one write clears", 5'd4);

        // R6 enable gates the interrupt
        cyc(8'h00, 1'b0, 1'b1, 5'd5, 8'h20);
        rd("R6 enable readback", 5'd5);
        cyc(8'h20, 1'b0, 1'b0, 5'd0, 8'h00);
        chk("R6 irq raised", {7'd0, irq_o}, 8'h01);
        cyc(8'h00, 1'b0, 1'b1, 5'd4, 8'h20);
        chk("R6 irq dropped", {7'd0, irq_o}, 8'h00);

        // R5 an event in the same cycle as a clear keeps the bit set
        cyc(8'h10, 1'b0, 1'b1, 5'd4, 8'h10);
        rd("R5 event wins", 5'd4);

        // R7 release pulse on a clear of a set receive flag; R8 nothing on a second clear
        cyc(8'h01, 1'b0, 1'b0, 5'd0, 8'h00);
        cyc(8'h00, 1'b0, 1'b1, 5'd4, 8'h01);
        chk("R7 release pulse", {7'd0, rx_release_o}, 8'h01);
        rd("R7 receive flag cleared", 5'd4);
        cyc(8'h00, 1'b0, 1'b0, 5'd0, 8'h00);
        chk("R7 pulse lasts one cycle", {7'd0, rx_release_o}, 8'h00);
        cyc(8'h00, 1'b0, 1'b1, 5'd4, 8'h01);
        chk("R8 no release on idle clear", {7'd0, rx_release_o}, 8'h00);
        rd("R8 flag still clear", 5'd4);

        // R9 send-available bit follows the level and cannot be cleared
        cyc(8'h00, 1'b1, 1'b0, 5'd0, 8'h00);
        rd("R9 follows level", 5'd4);
        cyc(8'h00, 1'b1, 1'b1, 5'd4, 8'h02);
        rd("R9 clear ignored", 5'd4);
        cyc(8'h02, 1'b0, 1'b0, 5'd0, 8'h00);
        rd("R9 event ignored", 5'd4);

        // R10 unmapped address
        cyc(8'h00, 1'b0, 1'b1, 5'd9, 8'hFF);
        rd("R10 unmapped read", 5'd9);
        rd("R10 flag untouched", 5'd4);
        rd("R10 enable untouched", 5'd5);

        // Random phase covering R3 through R9
        for (int k = 0; k < 3000; k++) begin
            logic [7:0] ev;
            logic [4:0] a;
            logic       w;
            ev = 8'(($urandom % 4 == 0) ? (8'd1 << ($urandom % 8)) : 0);
            w  = ($urandom % 3) == 0;
            case ($urandom % 5)
                0, 1:    a = 5'd4;
                2:       a = 5'd5;
                3:       a = 5'd18;
                default: a = 5'd9;
            endcase
            cyc(ev, 1'($urandom % 2), w, a, 8'($urandom));
            rd("R4 random flag", 5'd4);
            rd("R6 random enable", 5'd5);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule